// File: doc/BRIEF.md
# Dual-I/O Serial Flash Read Responder

This block plays the memory side of a serial flash link for one operation: a fast read whose address and data move over two lines at once. A host lowers chip select and clocks in an 8-bit opcode, one bit per clock on line 0. It then sends a 24-bit address as twelve pairs of bits on both lines, followed by a run of idle turnaround clocks. After that the responder drives the addressed byte and each following byte two bits per clock until chip select rises. The address counter steps after every byte and wraps at the top of the array, so one command can read the array any number of times over.

The serial clock, chip select and data lines are oversampled by a faster system clock. Inputs are captured on rising serial-clock edges and outputs change on falling ones. Both idle levels of the serial clock are accepted. The pad lines are split into input, output and per-line enable, so the pad ring can build the bidirectional pins. A busy input stands for an internal write or erase cycle. While it is set, a read command is refused and the lines stay released. The storage is a small array with computed content, indexed by the address modulo its depth.

Top module: `dualIoReadResponder`

## Requirements
- R1: After chip select falls, the first 8 rising serial-clock edges shift an opcode in on line 0, most significant bit first. Only opcode 0xBB starts a read. Any other opcode leaves both lines released until chip select rises.
- R2: The next 12 rising edges take the 24-bit address two bits at a time, highest pair first. Line 1 carries the odd-numbered bit and line 0 the even-numbered bit of each pair. The array index is the address modulo DEPTH.
- R3: DUMMY_CYC rising edges (default 4) follow the address. Through the opcode, address and turnaround phases both line enables stay low.
- R4: In the data phase each byte takes 4 clocks, highest pair first. Line 1 carries bits 7, 5, 3, 1 and line 0 carries bits 6, 4, 2, 0. The first pair appears after the falling edge that follows the last turnaround rising edge, and the output changes only after falling edges.
- R5: The array byte at index i equals the low 8 bits of i XOR FILL_KEY.
- R6: After each byte the index steps by one, so bytes stream without limit while the clock runs.
- R7: After the byte at index DEPTH-1, the next byte comes from index 0.
- R8: Chip select rising at any point, including mid-byte, releases both lines within 4 system clocks. The next chip select fall restarts opcode reception.
- R9: If busy is high when the eighth opcode bit is taken, the read is refused and no line is driven for the rest of that selection, even if busy drops.
- R10: Reads work with the serial clock idling low (mode 0) and idling high (mode 3).
- R11: Out of reset both line enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial link |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select from the host |
| busy | input | 1 | High while a write or erase cycle is in progress |
| sioIn | input | 2 | Levels seen on the two data pins |
| sioOut | output | 2 | Values to drive on the two data pins |
| sioOe | output | 2 | Per-pin drive enable, high in the data phase only |

## Verification
The bench builds the responder with DEPTH set to 32 and FILL_KEY set to 0x5A. The turnaround count stays at its default of 4. A 32-byte array lets a four-byte read that starts at an address whose low bits are 0x1E cross the top of the array and come back to index 0, all within a few dozen serial clocks. The start address also carries set upper bits, which shows that only the low index bits select the byte. The non-default key gives every byte a value distinct from its own index, so a byte read from the wrong index or with pairs in the wrong order shows up as a mismatch.

// File: rtl/dualIoRdPkg.sv
package dualIoRdPkg;

  localparam logic [7:0] DUAL_READ_OP = 8'hBB;
  localparam int ADDR_PAIRS = 12;
  localparam int OP_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_ADDR,
    ST_TURN,
    ST_DATA,
    ST_REFUSED
  } rdState_t;

  typedef struct packed {
    logic       capOp;
    logic       capAddr;
    logic       stepOut;
    logic [1:0] pairIdx;
    logic       lastPair;
  } rdStrobe_t;

endpackage

// File: rtl/dualIoRdCtrl.sv
module dualIoRdCtrl
  import dualIoRdPkg::*;
#(
  parameter int DUMMY_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       busy,
  input  logic [1:0] sioIn,
  input  logic       opMatch,
  output logic [1:0] sioSync,
  output rdStrobe_t  stb,
  output logic       dataPhase
);

  localparam int CNT_MAX = (DUMMY_CYC > ADDR_PAIRS) ? DUMMY_CYC : ADDR_PAIRS;
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  logic [1:0] sclkS;
  logic [1:0] csS;
  logic [1:0] sioS0;
  logic [1:0] sioS1;
  logic       sclkPrev;
  logic       csPrev;
  logic       rise;
  logic       fall;
  logic       csHigh;
  logic       csFallEdge;
  rdState_t   state;
  logic [CNT_W-1:0] cnt;

  // two-stage synchronizers, equal depth keeps edges and data aligned
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkS    <= '0;
      csS      <= 2'b11;
      sioS0    <= '0;
      sioS1    <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkS    <= {sclkS[0], sclk};
      csS      <= {csS[0], csN};
      sioS0    <= {sioS0[0], sioIn[0]};
      sioS1    <= {sioS1[0], sioIn[1]};
      sclkPrev <= sclkS[1];
      csPrev   <= csS[1];
    end
  end

  assign rise       = sclkS[1] & ~sclkPrev;
  assign fall       = ~sclkS[1] & sclkPrev;
  assign csHigh     = csS[1];
  assign csFallEdge = ~csS[1] & csPrev;
  assign sioSync    = {sioS1[1], sioS0[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (csHigh) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (csFallEdge) begin
      state <= ST_OPCODE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_OPCODE: if (rise) begin
          if (cnt == CNT_W'(OP_BITS - 1)) begin
            state <= (opMatch && !busy) ? ST_ADDR : ST_REFUSED;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ADDR: if (rise) begin
          if (cnt == CNT_W'(ADDR_PAIRS - 1)) begin
            state <= ST_TURN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TURN: if (rise) begin
          if (cnt == CNT_W'(DUMMY_CYC - 1)) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: if (fall) begin
          cnt <= (cnt[1:0] == 2'd3) ? '0 : cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    stb.capOp    = (state == ST_OPCODE) && rise && !csHigh && !csFallEdge;
    stb.capAddr  = (state == ST_ADDR) && rise && !csHigh;
    stb.stepOut  = (state == ST_DATA) && fall && !csHigh;
    stb.pairIdx  = cnt[1:0];
    stb.lastPair = (cnt[1:0] == 2'd3);
  end

  assign dataPhase = (state == ST_DATA);

  AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPCODE && rise && busy && !csHigh && !csFallEdge &&
     cnt == CNT_W'(OP_BITS - 1)) |=> (state != ST_ADDR)) // R9
    else $error("read accepted while busy");

  AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> !dataPhase) // R8
    else $error("lines driven after deselect");

  AST_RESTART_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    (csFallEdge && !csHigh) |=> (state == ST_OPCODE)) // R1
    else $error("select fall did not restart opcode phase");

  AST_DATA_AFTER_TURN: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dataPhase)) |-> ($past(state) == ST_TURN)) // R3
    else $error("data phase entered without turnaround");

endmodule

// File: rtl/dualIoRdPath.sv
module dualIoRdPath
  import dualIoRdPkg::*;
#(
  parameter int         DEPTH    = 256,
  parameter logic [7:0] FILL_KEY = 8'hA5
) (
  input  logic       clk,
  input  logic       rstN,
  input  rdStrobe_t  stb,
  input  logic [1:0] sioSync,
  output logic       opMatch,
  output logic [1:0] sioOut
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [6:0]       opShift;
  logic [IDX_W-1:0] idx;
  logic [7:0]       memArr [DEPTH];
  logic [7:0]       curByte;
  logic [7:0]       pairSel;

  for (genvar gI = 0; gI < DEPTH; gI++) begin : g_fill
    assign memArr[gI] = 8'(gI) ^ FILL_KEY;
  end

  assign opMatch = ({opShift, sioSync[0]} == DUAL_READ_OP);
  assign curByte = memArr[idx];
  assign pairSel = curByte << {stb.pairIdx, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opShift <= '0;
      idx     <= '0;
      sioOut  <= '0;
    end else begin
      if (stb.capOp) begin
        opShift <= {opShift[5:0], sioSync[0]};
      end
      // only the low index bits of the 24-bit address survive the shift
      if (stb.capAddr) begin
        idx <= {idx[IDX_W-3:0], sioSync[1], sioSync[0]};
      end else if (stb.stepOut && stb.lastPair) begin
        idx <= idx + 1'b1;
      end
      if (stb.stepOut) begin
        sioOut <= pairSel[7:6];
      end
    end
  end

  AST_INDEX_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepOut && stb.lastPair && !stb.capAddr && (&idx)) |=> (idx == '0)) // R7
    else $error("index did not wrap to zero");

  AST_OUT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !stb.stepOut |=> $stable(sioOut)) // R4
    else $error("output moved without a falling edge");

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepOut && !stb.lastPair && !stb.capAddr) |=> $stable(idx)) // R6
    else $error("index moved mid-byte");

endmodule

// File: rtl/dualIoReadResponder.sv
module dualIoReadResponder
  import dualIoRdPkg::*;
#(
  parameter int         DEPTH     = 256,
  parameter int         DUMMY_CYC = 4,
  parameter logic [7:0] FILL_KEY  = 8'hA5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       busy,
  input  logic [1:0] sioIn,
  output logic [1:0] sioOut,
  output logic [1:0] sioOe
);

  rdStrobe_t  stb;
  logic [1:0] sioSync;
  logic       opMatch;
  logic       dataPhase;

  dualIoRdCtrl #(.DUMMY_CYC(DUMMY_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclk     (sclk),
    .csN      (csN),
    .busy     (busy),
    .sioIn    (sioIn),
    .opMatch  (opMatch),
    .sioSync  (sioSync),
    .stb      (stb),
    .dataPhase(dataPhase)
  );

  dualIoRdPath #(.DEPTH(DEPTH), .FILL_KEY(FILL_KEY)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .sioSync (sioSync),
    .opMatch (opMatch),
    .sioOut  (sioOut)
  );

  assign sioOe = {2{dataPhase}};

  AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (sioOe == 2'b00)) // R11
    else $error("lines driven out of reset");

endmodule

// File: tb/sim_dualIoReadResponder.sv
module sim_dualIoReadResponder;

  localparam int DEPTH = 32;
  localparam logic [7:0] KEY = 8'h5A;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclk = 1'b0;
  logic       csN = 1'b1;
  logic       busy = 1'b0;
  logic       hostEn = 1'b0;
  logic [1:0] hostVal = 2'b00;
  logic [1:0] sioIn;
  logic [1:0] sioOut;
  logic [1:0] sioOe;
  int checks = 0;
  int fails = 0;
  int leaks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign sioIn[0] = sioOe[0] ? sioOut[0] : (hostEn ? hostVal[0] : 1'b0);
  assign sioIn[1] = sioOe[1] ? sioOut[1] : (hostEn ? hostVal[1] : 1'b0);

  dualIoReadResponder #(.DEPTH(DEPTH), .DUMMY_CYC(4), .FILL_KEY(KEY)) u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .busy(busy),
    .sioIn(sioIn), .sioOut(sioOut), .sioOe(sioOe)
  );

  function automatic logic [7:0] expByte(input int a);
    return 8'(a % DEPTH) ^ KEY;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one serial clock: fall, hold, sample, rise, hold
  task automatic sclkCycle(input logic [1:0] drv, input bit en,
                           output logic [1:0] got, output logic [1:0] oeSeen);
    sclk = 1'b0;
    hostEn = en;
    hostVal = drv;
    tick(HALF);
    got = sioIn;
    oeSeen = sioOe;
    sclk = 1'b1;
    tick(HALF);
  endtask

  task automatic openTxn(input bit mode3);
    sclk = mode3;
    tick(2);
    csN = 1'b0;
    tick(4);
  endtask

  task automatic closeTxn(input bit mode3);
    if (!mode3) begin
      sclk = 1'b0;
      tick(HALF);
    end
    csN = 1'b1;
    hostEn = 1'b0;
    tick(8);
  endtask

  task automatic sendOp(input logic [7:0] op);
    logic [1:0] g, o;
    for (int i = 7; i >= 0; i--) begin
      sclkCycle({1'b0, op[i]}, 1'b1, g, o);
      if (o != 2'b00) leaks++;
    end
  endtask

  task automatic sendAddr(input logic [23:0] a);
    logic [1:0] g, o;
    for (int p = 11; p >= 0; p--) begin
      sclkCycle({a[2*p+1], a[2*p]}, 1'b1, g, o);
      if (o != 2'b00) leaks++;
    end
  endtask

  task automatic turnaround(input int n);
    logic [1:0] g, o;
    for (int i = 0; i < n; i++) begin
      sclkCycle(2'b00, 1'b0, g, o);
      if (o != 2'b00) leaks++;
    end
  endtask

  task automatic readBytes(input int startIdx, input int n, input string req);
    logic [1:0] g, o;
    logic [7:0] b;
    bit oeOk;
    for (int k = 0; k < n; k++) begin
      b = '0;
      oeOk = 1;
      for (int p = 0; p < 4; p++) begin
        sclkCycle(2'b00, 1'b0, g, o);
        b = {b[5:0], g};
        if (o != 2'b11) oeOk = 0;
      end
      check(b == expByte(startIdx + k), req, b, expByte(startIdx + k));
      check(oeOk, {req, " drive"}, 0, 1);
    end
  endtask

  task automatic testReset;
    check(sioOe == 2'b00, "R11 reset enables", sioOe, 0);
  endtask

  task automatic testBasicMode0;
    leaks = 0;
    openTxn(1'b0);
    sendOp(8'hBB);
    sendAddr(24'h000005);
    turnaround(4);
    check(leaks == 0, "R3 no drive before data", leaks, 0);
    readBytes(5, 3, "R2 R4 R5 R6 mode0 stream");
    closeTxn(1'b0);
    check(sioOe == 2'b00, "R8 released after close", sioOe, 0);
  endtask

  task automatic testWrapMode3;
    leaks = 0;
    openTxn(1'b1);
    sendOp(8'hBB);
    sendAddr(24'hABCD1E);
    turnaround(4);
    check(leaks == 0, "R3 mode3 no early drive", leaks, 0);
    readBytes(30, 4, "R7 R10 R2 wrap mode3");
    closeTxn(1'b1);
  endtask

  task automatic testBusy;
    leaks = 0;
    busy = 1'b1;
    openTxn(1'b0);
    sendOp(8'hBB);
    busy = 1'b0;
    sendAddr(24'h000003);
    turnaround(12);
    check(leaks == 0, "R9 refused while busy", leaks, 0);
    closeTxn(1'b0);
    leaks = 0;
    openTxn(1'b0);
    sendOp(8'hBB);
    sendAddr(24'h000003);
    turnaround(4);
    readBytes(3, 1, "R9 accepted once idle");
    closeTxn(1'b0);
  endtask

  task automatic testBadOp;
    leaks = 0;
    openTxn(1'b0);
    sendOp(8'h3B);
    sendAddr(24'h000001);
    turnaround(12);
    check(leaks == 0, "R1 foreign opcode ignored", leaks, 0);
    closeTxn(1'b0);
  endtask

  task automatic testAbort;
    logic [1:0] g, o;
    openTxn(1'b0);
    sendOp(8'hBB);
    sendAddr(24'h000007);
    turnaround(4);
    sclkCycle(2'b00, 1'b0, g, o);
    check(g == expByte(7) >> 6, "R4 first pair", g, expByte(7) >> 6);
    sclk = 1'b0;
    tick(2);
    csN = 1'b1;
    tick(4);
    check(sioOe == 2'b00, "R8 release mid-byte", sioOe, 0);
    tick(4);
    openTxn(1'b0);
    sendOp(8'hBB);
    sendAddr(24'h000012);
    turnaround(4);
    readBytes(18, 2, "R8 restart after abort");
    closeTxn(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    testReset();
    rstN = 1'b1;
    tick(4);
    testBasicMode0();
    testWrapMode3();
    testBusy();
    testBadOp();
    testAbort();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule